// File: doc/BRIEF.md
# Card Window Address Decoder

This block sits between a host bus and a two-slot PC card interface. It holds eight programmable windows. Each window has a base register and an option register. On every host access it decides which window, if any, claims the address. For that window it reports the target slot, the address space (common memory, attribute memory or I/O), the port width, the strobe timing fields and the card-side offset. It also decides whether a write may go through to the card.

Software programs the windows through a narrow register write port. The host then presents `host_valid`, `host_write` and `host_addr`. One clock later the decoder answers with the access descriptor and one of three outcomes: a card read strobe, a card write strobe, or a write-error pulse. There is no offset register, so the card offset is the host address with the bits above the window size removed. Window sizes use a scrambled 5-bit code with reserved holes. A window with a reserved code behaves as if it were switched off.

Top module: `card_win_decoder`

## Requirements
- R1: After reset every window is invalid, so no access hits. All registered outputs (`acc_hit`, `acc_win`, `acc_slot`, `acc_space`, `acc_wide`, `acc_timing`, `acc_offset`, `card_rd`, `card_wr`, `write_err`) are zero.
- R2: A register write with `reg_addr[0]=0` loads the base of window `reg_addr[3:1]` and `reg_addr[0]=1` loads its option word. Host accesses see the new value from the following clock on.
- R3: Option bits 31:27 hold the size code, with these window sizes in bytes:
  - codes 0-3: 1, 2, 8, 4
  - codes 4-7: 128, 64, 16, 32
  - codes 8-11: 32K, 16K, 4K, 8K
  - codes 12-15: 256, 512, 2K, 1K
  - codes 20, 21, 23: 16M, 32M, 64M
  - codes 24-27: 64K, 128K, 512K, 256K
  - codes 28-31: 8M, 4M, 1M, 2M
- R4: Size codes 16, 17, 18, 19 and 22 are reserved. A window carrying one of them never hits.
- R5: Option bit 0 is the valid bit. A window with it clear never hits.
- R6: A window hits when the host address bits at and above log2(size) equal the same bits of its base. Base bits below the size are ignored. `acc_offset` is the host address with those upper bits cleared.
- R7: When several windows hit, the lowest-numbered one is reported in `acc_win` and supplies all descriptor fields.
- R8: The winning window's option bit 2 is driven on `acc_slot` (0 = slot A, 1 = slot B). Bits 4:3 are driven on `acc_space` (00 common, 10 attribute, 11 I/O, 01 passed through unchanged). Bit 6 is driven on `acc_wide` (1 = 16-bit port).
- R9: `acc_timing` carries the winning window's strobe timing fields as {hold = bits 19:16, setup = bits 15:12, strobe length = bits 11:7}.
- R10: Option bit 1 is write protect.
  - A write that hits a protected window gives `card_wr=0` and `write_err=1` for one cycle.
  - A read of a protected window still gives `card_rd=1`.
  - A write to an unprotected window gives `card_wr=1`.
- R11: Results appear in the clock cycle after the one in which `host_valid` is sampled and last one cycle. A miss, or a cycle without a request, gives `acc_hit=0`, `card_rd=0`, `card_wr=0` and `write_err=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | {window index, option/base select} |
| reg_wdata | input | 32 | Register write data |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | Host access is a write |
| host_addr | input | 32 | Host byte address |
| acc_hit | output | 1 | A window claimed the access |
| acc_win | output | 3 | Index of the winning window |
| acc_slot | output | 1 | Target slot of the winning window |
| acc_space | output | 2 | Address space of the winning window |
| acc_wide | output | 1 | 16-bit port selected |
| acc_timing | output | 13 | {hold, setup, strobe} timing fields |
| acc_offset | output | 32 | Card-side offset |
| card_rd | output | 1 | Read forwarded to the card |
| card_wr | output | 1 | Write forwarded to the card |
| write_err | output | 1 | Write blocked by write protect |

## Verification
The bench builds the decoder with its default parameters: eight windows, a 32-bit address and a 4-bit register address. This puts every one of the 32 size codes within reach, up to the 64 MB window whose mask clears bit 26. It also lets the highest window index, 7, be programmed and reported. Every size code, valid and reserved, is swept on one window, checking both the last in-range byte and the first byte past it. Overlapping windows, protected writes and the register-port field positions are each covered with their own directed scenario.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  typedef enum logic [1:0] {
    SP_COMMON = 2'b00,
    SP_RSVD   = 2'b01,
    SP_ATTR   = 2'b10,
    SP_IO     = 2'b11
  } space_e;

  typedef struct packed {
    logic [4:0] size_code;
    logic [6:0] rsv_a;
    logic [3:0] hold;
    logic [3:0] setup;
    logic [4:0] strobe;
    logic       wide;
    logic       rsv_b;
    space_e     space;
    logic       slot;
    logic       wprot;
    logic       valid;
  } win_opt_t;

  // Returns {code_ok, log2(size)} for a scrambled size code.
  function automatic logic [5:0] size_decode(input logic [4:0] code);
    logic [4:0] lg;
    logic       ok;
    ok = 1'b1;
    case (code)
      5'd0:  lg = 5'd0;   5'd1:  lg = 5'd1;   5'd2:  lg = 5'd3;   5'd3:  lg = 5'd2;
      5'd4:  lg = 5'd7;   5'd5:  lg = 5'd6;   5'd6:  lg = 5'd4;   5'd7:  lg = 5'd5;
      5'd8:  lg = 5'd15;  5'd9:  lg = 5'd14;  5'd10: lg = 5'd12;  5'd11: lg = 5'd13;
      5'd12: lg = 5'd8;   5'd13: lg = 5'd9;   5'd14: lg = 5'd11;  5'd15: lg = 5'd10;
      5'd20: lg = 5'd24;  5'd21: lg = 5'd25;  5'd23: lg = 5'd26;
      5'd24: lg = 5'd16;  5'd25: lg = 5'd17;  5'd26: lg = 5'd19;  5'd27: lg = 5'd18;
      5'd28: lg = 5'd23;  5'd29: lg = 5'd22;  5'd30: lg = 5'd20;  5'd31: lg = 5'd21;
      default: begin lg = 5'd0; ok = 1'b0; end
    endcase
    return {ok, lg};
  endfunction

endpackage

// File: rtl/cwd_regfile.sv
module cwd_regfile
  import cwd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int REG_AW = IDX_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_wr,
  input  logic [REG_AW-1:0]                reg_addr,
  input  logic [31:0]                      reg_wdata,
  output logic [NUM_WIN-1:0][ADDR_W-1:0]   base_q,
  output win_opt_t [NUM_WIN-1:0]           opt_q
);

  logic [IDX_W-1:0] wr_idx;
  logic             wr_opt;
  assign wr_idx = reg_addr[REG_AW-1:1];
  assign wr_opt = reg_addr[0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel;
    assign sel = reg_wr && (wr_idx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[w] <= '0;
        opt_q[w]  <= '0;
      end else if (sel) begin
        if (wr_opt) opt_q[w]  <= win_opt_t'(reg_wdata);
        else        base_q[w] <= reg_wdata[ADDR_W-1:0];
      end
    end
  end

  // R2
  opt_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wr_opt) |=> (32'(opt_q[$past(wr_idx)]) == $past(reg_wdata)));

  // R2
  base_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !wr_opt) |=> (base_q[$past(wr_idx)] == $past(reg_wdata[ADDR_W-1:0])));

endmodule

// File: rtl/cwd_win_match.sv
module cwd_win_match
  import cwd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [4:0]        size_code,
  input  logic              valid,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);

  logic [5:0]        dec;
  logic              code_ok;
  logic [4:0]        lg;
  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    dec      = size_decode(size_code);
    code_ok  = dec[5];
    lg       = dec[4:0];
    low_mask = (ADDR_W'(1) << lg) - ADDR_W'(1);
    hit      = valid && code_ok && ((host_addr & ~low_mask) == (base & ~low_mask));
    offset   = host_addr & low_mask;
  end

endmodule

// File: rtl/cwd_prio.sv
module cwd_prio #(
  parameter int NUM_WIN = 8,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] hits,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/card_win_decoder.sv
module card_win_decoder
  import cwd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int REG_AW = IDX_W + 1,
  localparam int TIM_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              acc_hit,
  output logic [IDX_W-1:0]  acc_win,
  output logic              acc_slot,
  output logic [1:0]        acc_space,
  output logic              acc_wide,
  output logic [TIM_W-1:0]  acc_timing,
  output logic [ADDR_W-1:0] acc_offset,
  output logic              card_rd,
  output logic              card_wr,
  output logic              write_err
);

  logic [NUM_WIN-1:0][ADDR_W-1:0] base_q;
  win_opt_t [NUM_WIN-1:0]         opt_q;
  logic [NUM_WIN-1:0]             win_hits;
  logic [NUM_WIN-1:0][ADDR_W-1:0] win_offs;
  logic                           any_hit;
  logic [IDX_W-1:0]               sel_idx;
  win_opt_t                       sel_opt;
  logic                           take;
  logic                           unused_rsv;

  cwd_regfile #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .base_q(base_q), .opt_q(opt_q)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    cwd_win_match #(.ADDR_W(ADDR_W)) u_match (
      .base(base_q[w]), .size_code(opt_q[w].size_code), .valid(opt_q[w].valid),
      .host_addr(host_addr), .hit(win_hits[w]), .offset(win_offs[w])
    );
  end

  cwd_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .hits(win_hits), .any(any_hit), .idx(sel_idx)
  );

  assign sel_opt    = opt_q[sel_idx];
  assign take       = host_valid && any_hit;
  assign unused_rsv = ^{sel_opt.rsv_a, sel_opt.rsv_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_hit    <= 1'b0;
      acc_win    <= '0;
      acc_slot   <= 1'b0;
      acc_space  <= '0;
      acc_wide   <= 1'b0;
      acc_timing <= '0;
      acc_offset <= '0;
      card_rd    <= 1'b0;
      card_wr    <= 1'b0;
      write_err  <= 1'b0;
    end else begin
      acc_hit    <= take;
      acc_win    <= take ? sel_idx : '0;
      acc_slot   <= take && sel_opt.slot;
      acc_space  <= take ? sel_opt.space : 2'b00;
      acc_wide   <= take && sel_opt.wide;
      acc_timing <= take ? {sel_opt.hold, sel_opt.setup, sel_opt.strobe} : '0;
      acc_offset <= take ? win_offs[sel_idx] : '0;
      card_rd    <= take && !host_write;
      card_wr    <= take && host_write && !sel_opt.wprot;
      write_err  <= take && host_write && sel_opt.wprot;
    end
  end

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (win_hits[sel_idx] &&
                 ((win_hits & ((NUM_WIN'(1) << sel_idx) - NUM_WIN'(1))) == '0)));

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({card_rd, card_wr, write_err}));

  // R10
  err_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_write) |=> !write_err && !card_wr);

  // R11
  strobe_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rd || card_wr || write_err) |-> acc_hit);

  // R11
  idle_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_valid |=> !acc_hit);

endmodule

// File: tb/tb_card_win_decoder.sv
module tb_card_win_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        host_valid, host_write;
  logic [31:0] host_addr;
  logic        acc_hit, acc_slot, acc_wide, card_rd, card_wr, write_err;
  logic [2:0]  acc_win;
  logic [1:0]  acc_space;
  logic [12:0] acc_timing;
  logic [31:0] acc_offset;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  card_win_decoder dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .acc_hit(acc_hit), .acc_win(acc_win), .acc_slot(acc_slot), .acc_space(acc_space),
    .acc_wide(acc_wide), .acc_timing(acc_timing), .acc_offset(acc_offset),
    .card_rd(card_rd), .card_wr(card_wr), .write_err(write_err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Byte size per code; 0 marks a reserved code.
  function automatic longint unsigned code_bytes(input int c);
    case (c)
      0: return 1;        1: return 2;        2: return 8;        3: return 4;
      4: return 128;      5: return 64;       6: return 16;       7: return 32;
      8: return 32768;    9: return 16384;    10: return 4096;    11: return 8192;
      12: return 256;     13: return 512;     14: return 2048;    15: return 1024;
      20: return 1 << 24; 21: return 1 << 25; 23: return 1 << 26;
      24: return 65536;   25: return 131072;  26: return 524288;  27: return 262144;
      28: return 1 << 23; 29: return 1 << 22; 30: return 1 << 20; 31: return 1 << 21;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] mkopt(input int code, input bit slot, input logic [1:0] sp,
                                        input bit wide, input bit wp, input bit vld,
                                        input logic [3:0] hold, input logic [3:0] setup,
                                        input logic [4:0] strobe);
    return {5'(code), 7'd0, hold, setup, strobe, wide, 1'b0, sp, slot, wp, vld};
  endfunction

  task automatic wreg(input int win, input bit is_opt, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {3'(win), is_opt}; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic setwin(input int win, input logic [31:0] base, input logic [31:0] opt);
    wreg(win, 1'b0, base);
    wreg(win, 1'b1, opt);
  endtask

  task automatic clear_all();
    for (int w = 0; w < 8; w++) wreg(w, 1'b1, 32'd0);
  endtask

  // Drive one access; on return the registered results are stable.
  task automatic access(input logic [31:0] a, input bit wr);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_addr = a;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 acc_hit", acc_hit, 0);
    chk("R1 strobes", {card_rd, card_wr, write_err}, 0);
    chk("R1 fields", {acc_win, acc_slot, acc_space, acc_wide, acc_timing, acc_offset}, 0);
    access(32'h0000_0000, 1'b0);
    chk("R1 miss after reset", {acc_hit, card_rd}, 0);
  endtask

  task automatic t_sizes();
    clear_all();
    wreg(0, 1'b0, 32'h1000_0000);
    for (int c = 0; c < 32; c++) begin
      longint unsigned sz = code_bytes(c);
      wreg(0, 1'b1, mkopt(c, 0, 2'b00, 0, 0, 1, 0, 0, 0));
      if (sz != 0) begin
        access(32'h1000_0000 + 32'(sz - 1), 1'b0);
        chk($sformatf("R3 code %0d top byte hit", c), acc_hit, 1);
        chk($sformatf("R3 code %0d offset", c), acc_offset, sz - 1);
        access(32'h1000_0000 + 32'(sz), 1'b0);
        chk($sformatf("R3 code %0d past end miss", c), acc_hit, 0);
      end else begin
        access(32'h1000_0000, 1'b0);
        chk($sformatf("R4 reserved code %0d miss", c), {acc_hit, card_rd}, 0);
      end
    end
  endtask

  task automatic t_valid();
    clear_all();
    setwin(1, 32'h3000_0000, mkopt(10, 0, 2'b00, 0, 0, 0, 0, 0, 0));
    access(32'h3000_0010, 1'b0);
    chk("R5 invalid window miss", acc_hit, 0);
    wreg(1, 1'b1, mkopt(10, 0, 2'b00, 0, 0, 1, 0, 0, 0));
    access(32'h3000_0010, 1'b0);
    chk("R5 valid window hit", {acc_hit, acc_win}, {1'b1, 3'd1});
  endtask

  task automatic t_match();
    clear_all();
    setwin(3, 32'h2000_0123, mkopt(10, 0, 2'b00, 0, 0, 1, 0, 0, 0));
    access(32'h2000_0ABC, 1'b0);
    chk("R6 hit ignoring base low bits", acc_hit, 1);
    chk("R6 offset", acc_offset, 32'h0000_0ABC);
    access(32'h2000_1000, 1'b0);
    chk("R6 above window miss", acc_hit, 0);
    access(32'h1FFF_FFFF, 1'b0);
    chk("R6 below window miss", acc_hit, 0);
  endtask

  task automatic t_prio();
    clear_all();
    setwin(5, 32'h4000_0000, mkopt(24, 1, 2'b11, 0, 0, 1, 0, 0, 0));
    setwin(2, 32'h4000_0000, mkopt(10, 0, 2'b10, 0, 0, 1, 0, 0, 0));
    access(32'h4000_0040, 1'b0);
    chk("R7 lower window wins", {acc_win, acc_slot, acc_space}, {3'd2, 1'b0, 2'b10});
    access(32'h4000_2000, 1'b0);
    chk("R7 only larger window covers", {acc_win, acc_slot, acc_space}, {3'd5, 1'b1, 2'b11});
    wreg(2, 1'b1, 32'd0);
    access(32'h4000_0040, 1'b0);
    chk("R7 falls to next window", acc_win, 3'd5);
  endtask

  task automatic t_fields();
    clear_all();
    setwin(7, 32'h5000_0000, mkopt(30, 1, 2'b11, 1, 0, 1, 4'hA, 4'h3, 5'h15));
    access(32'h5000_1234, 1'b0);
    chk("R8 slot/space/wide win7", {acc_win, acc_slot, acc_space, acc_wide}, {3'd7, 1'b1, 2'b11, 1'b1});
    chk("R9 timing", acc_timing, {4'hA, 4'h3, 5'h15});
    setwin(4, 32'h6000_0000, mkopt(3, 0, 2'b00, 0, 0, 1, 4'h1, 4'hE, 5'h02));
    access(32'h6000_0002, 1'b0);
    chk("R8 common 8-bit slot A", {acc_slot, acc_space, acc_wide}, {1'b0, 2'b00, 1'b0});
    chk("R9 timing second window", acc_timing, {4'h1, 4'hE, 5'h02});
    chk("R3 code 3 offset", acc_offset, 32'd2);
  endtask

  task automatic t_wprot();
    clear_all();
    setwin(6, 32'h7000_0000, mkopt(28, 0, 2'b00, 0, 1, 1, 0, 0, 0));
    access(32'h7000_0100, 1'b1);
    chk("R10 protected write blocked", {card_wr, write_err, acc_hit}, {1'b0, 1'b1, 1'b1});
    @(negedge clk);
    chk("R10 error lasts one cycle", write_err, 0);
    access(32'h7000_0100, 1'b0);
    chk("R10 protected read forwarded", {card_rd, write_err}, {1'b1, 1'b0});
    wreg(6, 1'b1, mkopt(28, 0, 2'b00, 0, 0, 1, 0, 0, 0));
    access(32'h7000_0100, 1'b1);
    chk("R10 unprotected write forwarded", {card_wr, write_err}, {1'b1, 1'b0});
  endtask

  task automatic t_latency();
    clear_all();
    setwin(0, 32'h8000_0000, mkopt(10, 0, 2'b00, 0, 0, 1, 0, 0, 0));
    access(32'h8000_0010, 1'b0);
    chk("R11 result next cycle", {acc_hit, card_rd}, 2'b11);
    @(negedge clk);
    chk("R11 result lasts one cycle", {acc_hit, card_rd}, 2'b00);
    access(32'h9000_0000, 1'b1);
    chk("R11 miss gives no strobe", {acc_hit, card_rd, card_wr, write_err}, 4'b0000);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    host_valid = 1'b0; host_write = 1'b0; host_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sizes();
    t_valid();
    t_match();
    t_prio();
    t_fields();
    t_wprot();
    t_latency();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule